// File: doc/BRIEF.md
# SEC-DED flow-through memory word corrector

This block sits between a system data bus and a memory array that stores a 32-bit data word beside 8 checkbits. Writes from the system side come out toward memory with checkbits computed over the word. A word read from memory is checked against the checkbits stored with it. One flag reports any mismatch and a second reports a mismatch that cannot be repaired. The repaired word is driven to the system side and also back toward memory with fresh checkbits, so that it can be scrubbed.

Byte-enabled writes are handled inside the block. Bytes that are selected take the new system data. The other bytes take the corrected old memory word, and the checkbits are computed over the merged result. The system bus carries one even-parity bit per byte: the block produces parity on its system output and checks parity on its system input. The memory input, the system input and the internal pipeline stage each have their own transparent hold stage with a separate enable. While the enable is high the stage passes its input straight through; while it is low the stage holds its value.

Top module: `secded_flow_edc`

## Requirements
- R1: Checkbit k is the XOR of every data bit j whose code column has bit k set. Data bit j uses the j-th 8-bit value, in ascending numeric order, that has exactly three ones (bit 0 uses 0x07, bit 1 uses 0x0B, bit 2 uses 0x0D). Checkbit k uses the column with only bit k set. With every byte enable set, `mem_d_out` equals the system word and `mem_cb_out` holds its checkbits.
- R2: Flipping any one of the 32 data bits in a stored codeword gives the original data on `sys_d_out`, with `err_any`=1 and `err_multi`=0.
- R3: Flipping any two distinct bits of the 40-bit codeword gives `err_any`=1 and `err_multi`=1.
- R4: A codeword with no error passes its data unchanged to `sys_d_out`, with both error flags at 0.
- R5: Byte b of `mem_d_out` is system byte b when `wr_be[b]`=1 and corrected memory byte b otherwise, and `mem_cb_out` holds the R1 checkbits of `mem_d_out`. With `wr_be`=0 this re-writes the corrected word.
- R6: The three hold stages (enables `mem_le`, `sys_le`, `pipe_le`) pass their input within the same cycle while the enable is high. While the enable is low, each shows the value its input had at the most recent rising clock edge at which the enable was high.
- R7: Each `sys_par_out[b]` makes the nine bits {`sys_par_out[b]`, `sys_d_out` byte b} hold an even number of ones. Byte b is bits 8b+7..8b.
- R8: `par_err` is 1 exactly when some byte of the held system input, taken together with its `sys_par_in` bit, holds an odd number of ones.
- R9: After a synchronous active-low reset, with all enables low, `sys_d_out`, `mem_d_out`, `mem_cb_out`, `err_any`, `err_multi` and `par_err` are all 0.
- R10: Flipping any one of the 8 stored checkbits leaves `sys_d_out` equal to the stored data, with `err_any`=1 and `err_multi`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold registers |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_le | input | 1 | Memory input stage enable (high = pass) |
| sys_le | input | 1 | System input stage enable (high = pass) |
| pipe_le | input | 1 | Pipeline stage enable (high = pass) |
| wr_be | input | 4 | Byte select for new system data |
| mem_d_in | input | 32 | Data word read from memory |
| mem_cb_in | input | 8 | Checkbits read from memory |
| sys_d_in | input | 32 | Data word from the system bus |
| sys_par_in | input | 4 | Even parity per byte from the system bus |
| sys_d_out | output | 32 | Corrected word toward the system |
| sys_par_out | output | 4 | Even parity per byte of `sys_d_out` |
| mem_d_out | output | 32 | Merged word toward memory |
| mem_cb_out | output | 8 | Checkbits of `mem_d_out` |
| err_any | output | 1 | Nonzero syndrome seen |
| err_multi | output | 1 | Error that cannot be corrected |
| par_err | output | 1 | System input parity mismatch |

## Verification
The bench builds the block with its default 32 data bits and 8 checkbits. With 40 codeword bits, every single-bit fault position and all 780 double-bit pairs are swept exhaustively over several stored words. All 16 byte-enable patterns are also swept, with a corrected old word, so that merging and checkbit regeneration are covered in full. Walking-one data words test each code column on its own, and each hold stage is closed in turn to show that it keeps its captured value.

// File: rtl/edc_pkg.sv
package edc_pkg;

    // Width of one parity-protected lane of the system bus.
    localparam int BYTE_W = 8;

    // Returns code column idx: the idx-th value, in ascending order,
    // that has exactly three ones within cbw bits. Used at elaboration.
    function automatic int unsigned hsiao_col(int unsigned idx, int unsigned cbw);
        int unsigned seen;
        int unsigned result;
        seen   = 0;
        result = 0;
        for (int unsigned v = 0; v < (32'd1 << cbw); v++) begin
            if ($countones(v) == 3) begin
                if (seen == idx) result = v;
                seen++;
            end
        end
        return result;
    endfunction

endpackage

// File: rtl/edc_hold_latch.sv
// edc_hold_latch
// Emulates a transparent latch in a clocked flow. While en is high the
// input flows straight to q. The value present at each rising edge with
// en high is captured, and q shows that capture while en is low.
// Assumes inputs settle between clock edges.
module edc_hold_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] held;

    // Capture the input on each edge at which the stage is open.
    always_ff @(posedge clk) begin
        if (!rst_n)  held <= '0;
        else if (en) held <= d;
    end

    // Open: flow through. Closed: show the capture.
    always_comb q = en ? d : held;

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(held));

endmodule

// File: rtl/edc_checkgen.sv
// edc_checkgen
// Computes CB_W checkbits over DATA_W data bits. Each data bit uses an
// odd-weight (three-ones) column. Requires at least DATA_W such columns
// among CB_W-bit values.
module edc_checkgen #(
    parameter int DATA_W = 32,
    parameter int CB_W   = 8
) (
    input  logic [DATA_W-1:0] data,
    output logic [CB_W-1:0]   cb
);

    logic [DATA_W-1:0][CB_W-1:0] term;

    for (genvar j = 0; j < DATA_W; j++) begin : g_col
        localparam logic [CB_W-1:0] COL = CB_W'(edc_pkg::hsiao_col(j, CB_W));
        assign term[j] = {CB_W{data[j]}} & COL;
    end

    // Fold all column contributions into the checkbit vector.
    always_comb begin
        cb = '0;
        for (int j = 0; j < DATA_W; j++) cb ^= term[j];
    end

endmodule

// File: rtl/edc_corrector.sv
// edc_corrector
// Forms the syndrome of a stored codeword and repairs one flipped data
// bit. A syndrome equal to a checkbit column flags an error and leaves
// the data as it is. Any other nonzero syndrome is uncorrectable.
module edc_corrector #(
    parameter int DATA_W = 32,
    parameter int CB_W   = 8
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [CB_W-1:0]   cb_in,
    output logic [DATA_W-1:0] data_out,
    output logic              err_any,
    output logic              err_multi
);

    logic [CB_W-1:0]   recomputed;
    logic [CB_W-1:0]   syndrome;
    logic [DATA_W-1:0] flip;
    logic [CB_W-1:0]   cb_hit;

    edc_checkgen #(.DATA_W(DATA_W), .CB_W(CB_W)) u_gen (
        .data (data_in),
        .cb   (recomputed)
    );

    assign syndrome = recomputed ^ cb_in;

    for (genvar j = 0; j < DATA_W; j++) begin : g_dmatch
        localparam logic [CB_W-1:0] COL = CB_W'(edc_pkg::hsiao_col(j, CB_W));
        assign flip[j] = (syndrome == COL);
    end

    for (genvar k = 0; k < CB_W; k++) begin : g_cmatch
        assign cb_hit[k] = (syndrome == (CB_W'(1) << k));
    end

    // Classify the syndrome and apply any single-bit repair.
    always_comb begin
        data_out  = data_in ^ flip;
        err_any   = |syndrome;
        err_multi = err_any && !(|flip) && !(|cb_hit);
    end

endmodule

// File: rtl/edc_byte_parity.sv
// edc_byte_parity
// Produces one even-parity bit per byte lane. Assumes DATA_W is a
// multiple of the byte width.
module edc_byte_parity #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]                 data,
    output logic [DATA_W/edc_pkg::BYTE_W-1:0] par
);

    localparam int LANES = DATA_W / edc_pkg::BYTE_W;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign par[b] = ^data[b*edc_pkg::BYTE_W +: edc_pkg::BYTE_W];
    end

endmodule

// File: rtl/secded_flow_edc.sv
// secded_flow_edc
// Flow-through SEC-DED corrector between a system bus and a memory
// array. Path: memory hold stage -> corrector -> pipeline hold stage ->
// system output, and byte merge with the held system input -> checkbit
// generation -> memory output. Assumes DATA_W is a multiple of 8.
module secded_flow_edc #(
    parameter int DATA_W = 32,
    parameter int CB_W   = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                mem_le,
    input  logic                                sys_le,
    input  logic                                pipe_le,
    input  logic [DATA_W/edc_pkg::BYTE_W-1:0]   wr_be,
    input  logic [DATA_W-1:0]                   mem_d_in,
    input  logic [CB_W-1:0]                     mem_cb_in,
    input  logic [DATA_W-1:0]                   sys_d_in,
    input  logic [DATA_W/edc_pkg::BYTE_W-1:0]   sys_par_in,
    output logic [DATA_W-1:0]                   sys_d_out,
    output logic [DATA_W/edc_pkg::BYTE_W-1:0]   sys_par_out,
    output logic [DATA_W-1:0]                   mem_d_out,
    output logic [CB_W-1:0]                     mem_cb_out,
    output logic                                err_any,
    output logic                                err_multi,
    output logic                                par_err
);

    localparam int BW    = edc_pkg::BYTE_W;
    localparam int LANES = DATA_W / BW;

    logic [DATA_W-1:0] mem_d_q;
    logic [CB_W-1:0]   mem_cb_q;
    logic [DATA_W-1:0] sys_d_q;
    logic [LANES-1:0]  sys_par_q;
    logic [DATA_W-1:0] cor_d;
    logic              cor_any;
    logic              cor_multi;
    logic [LANES-1:0]  sys_par_calc;

    // Memory-side input hold stage.
    edc_hold_latch #(.W(DATA_W + CB_W)) u_mem_hold (
        .clk (clk), .rst_n (rst_n), .en (mem_le),
        .d   ({mem_cb_in, mem_d_in}),
        .q   ({mem_cb_q, mem_d_q})
    );

    // System-side input hold stage.
    edc_hold_latch #(.W(DATA_W + LANES)) u_sys_hold (
        .clk (clk), .rst_n (rst_n), .en (sys_le),
        .d   ({sys_par_in, sys_d_in}),
        .q   ({sys_par_q, sys_d_q})
    );

    edc_corrector #(.DATA_W(DATA_W), .CB_W(CB_W)) u_fix (
        .data_in   (mem_d_q),
        .cb_in     (mem_cb_q),
        .data_out  (cor_d),
        .err_any   (cor_any),
        .err_multi (cor_multi)
    );

    // Pipeline hold stage on the corrected word and its flags.
    edc_hold_latch #(.W(DATA_W + 2)) u_pipe_hold (
        .clk (clk), .rst_n (rst_n), .en (pipe_le),
        .d   ({cor_multi, cor_any, cor_d}),
        .q   ({err_multi, err_any, sys_d_out})
    );

    // Byte merge: selected lanes take new system data.
    for (genvar b = 0; b < LANES; b++) begin : g_merge
        assign mem_d_out[b*BW +: BW] = wr_be[b] ? sys_d_q[b*BW +: BW]
                                                : sys_d_out[b*BW +: BW];
    end

    edc_checkgen #(.DATA_W(DATA_W), .CB_W(CB_W)) u_wgen (
        .data (mem_d_out),
        .cb   (mem_cb_out)
    );

    edc_byte_parity #(.DATA_W(DATA_W)) u_par_out (
        .data (sys_d_out),
        .par  (sys_par_out)
    );

    edc_byte_parity #(.DATA_W(DATA_W)) u_par_in (
        .data (sys_d_q),
        .par  (sys_par_calc)
    );

    // Flag any lane whose received parity disagrees.
    always_comb par_err = |(sys_par_calc ^ sys_par_q);

    // R3
    multi_implies_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_multi |-> err_any);

    // R4
    clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cor_any |-> (cor_d == mem_d_q));

    // R5
    scrub_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_be == '0) |-> (mem_d_out == sys_d_out));

    for (genvar b = 0; b < LANES; b++) begin : g_parchk
        // R7
        par_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones({sys_par_out[b], sys_d_out[b*BW +: BW]}) % 2) == 0);
    end

endmodule

// File: tb/secded_flow_edc_test.sv
module secded_flow_edc_test;

    localparam int DW = 32;
    localparam int CW = 8;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_le = 1'b0, sys_le = 1'b0, pipe_le = 1'b0;
    logic [NB-1:0] wr_be = '0;
    logic [DW-1:0] mem_d_in = '0, sys_d_in = '0;
    logic [CW-1:0] mem_cb_in = '0;
    logic [NB-1:0] sys_par_in = '0;
    logic [DW-1:0] sys_d_out, mem_d_out;
    logic [NB-1:0] sys_par_out;
    logic [CW-1:0] mem_cb_out;
    logic          err_any, err_multi, par_err;

    int checks = 0;
    int errors = 0;
    logic [7:0] col_tab [DW];

    always #10 clk = ~clk;

    secded_flow_edc uut (
        .clk (clk), .rst_n (rst_n), .mem_le (mem_le), .sys_le (sys_le),
        .pipe_le (pipe_le), .wr_be (wr_be), .mem_d_in (mem_d_in),
        .mem_cb_in (mem_cb_in), .sys_d_in (sys_d_in), .sys_par_in (sys_par_in),
        .sys_d_out (sys_d_out), .sys_par_out (sys_par_out), .mem_d_out (mem_d_out),
        .mem_cb_out (mem_cb_out), .err_any (err_any), .err_multi (err_multi),
        .par_err (par_err)
    );

    function automatic logic [7:0] tb_cb(logic [DW-1:0] d);
        logic [7:0] r = '0;
        for (int j = 0; j < DW; j++) if (d[j]) r = r ^ col_tab[j];
        return r;
    endfunction

    function automatic logic [NB-1:0] tb_par(logic [DW-1:0] d);
        logic [NB-1:0] p;
        for (int b = 0; b < NB; b++) p[b] = ($countones(d[b*8 +: 8]) % 2) == 1;
        return p;
    endfunction

    function automatic logic [39:0] tb_flip(logic [39:0] cw, int p);
        logic [39:0] r = cw;
        r[p] = ~r[p];
        return r;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_mem(logic [39:0] cw);
        @(negedge clk);
        mem_d_in  = cw[31:0];
        mem_cb_in = cw[39:32];
        #5;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] words [3];
        logic [39:0]   cw;
        logic [DW-1:0] oldw, neww, expw;
        int n;
        words[0] = 32'h0000_0000;
        words[1] = 32'hDEAD_BEEF;
        words[2] = 32'h5A0F_C3A1;

        // Column table from R1: ascending values with three ones.
        n = 0;
        for (int v = 0; v < 256; v++) begin
            if ($countones(v[7:0]) == 3 && n < DW) begin
                col_tab[n] = v[7:0];
                n++;
            end
        end

        // R9 reset state with every stage closed.
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        check("R9 sys_d_out", sys_d_out, 0);
        check("R9 mem_d_out", mem_d_out, 0);
        check("R9 mem_cb_out", mem_cb_out, 0);
        check("R9 flags", {err_any, err_multi, par_err}, 0);

        mem_le = 1'b1; sys_le = 1'b1; pipe_le = 1'b1;

        // R1 full writes: walking ones and fixed patterns.
        wr_be = '1;
        for (int i = 0; i < DW + 3; i++) begin
            @(negedge clk);
            sys_d_in = (i < DW) ? (32'd1 << i) : words[i - DW];
            #5;
            check("R1 mem_d_out", mem_d_out, sys_d_in);
            check("R1 mem_cb_out", mem_cb_out, tb_cb(sys_d_in));
        end

        // R4 clean reads, R5 scrub re-write, R7 parity out.
        wr_be = '0;
        for (int w = 0; w < 3; w++) begin
            load_mem({tb_cb(words[w]), words[w]});
            check("R4 data", sys_d_out, words[w]);
            check("R4 flags", {err_any, err_multi}, 0);
            check("R5 scrub data", mem_d_out, words[w]);
            check("R5 scrub cb", mem_cb_out, tb_cb(words[w]));
            check("R7 parity", sys_par_out, tb_par(words[w]));
        end

        // R2 and R10: every single-bit position.
        for (int w = 0; w < 3; w++) begin
            cw = {tb_cb(words[w]), words[w]};
            for (int p = 0; p < 40; p++) begin
                load_mem(tb_flip(cw, p));
                if (p < DW) begin
                    check("R2 data", sys_d_out, words[w]);
                    check("R2 flags", {err_any, err_multi}, 2'b10);
                end else begin
                    check("R10 data", sys_d_out, words[w]);
                    check("R10 flags", {err_any, err_multi}, 2'b10);
                end
            end
        end

        // R3: every double-bit pair.
        for (int w = 1; w < 3; w++) begin
            cw = {tb_cb(words[w]), words[w]};
            for (int p = 0; p < 40; p++) begin
                for (int q = p + 1; q < 40; q++) begin
                    load_mem(tb_flip(tb_flip(cw, p), q));
                    check("R3 flags", {err_any, err_multi}, 2'b11);
                end
            end
        end

        // R5 merges over all byte enables with a corrected old word.
        oldw = 32'h1234_5678;
        neww = 32'hCAFE_F00D;
        sys_d_in = neww;
        for (int be = 0; be < 16; be++) begin
            @(negedge clk);
            wr_be     = be[3:0];
            mem_d_in  = oldw ^ 32'h20;
            mem_cb_in = tb_cb(oldw);
            #5;
            for (int b = 0; b < NB; b++)
                expw[b*8 +: 8] = be[b] ? neww[b*8 +: 8] : oldw[b*8 +: 8];
            check("R5 merge data", mem_d_out, expw);
            check("R5 merge cb", mem_cb_out, tb_cb(expw));
        end

        // R8 parity checking on the system input.
        @(negedge clk);
        sys_d_in = words[1]; sys_par_in = tb_par(words[1]); #5;
        check("R8 good parity", par_err, 0);
        for (int b = 0; b < NB; b++) begin
            @(negedge clk);
            sys_par_in = tb_par(words[1]) ^ (4'b1 << b); #5;
            check("R8 bad parity bit", par_err, 1);
            @(negedge clk);
            sys_par_in = tb_par(words[1]);
            sys_d_in   = words[1] ^ (32'h1 << (b * 8 + 3)); #5;
            check("R8 bad data bit", par_err, 1);
            sys_d_in   = words[1];
        end

        // R6 memory stage hold.
        wr_be = '0;
        load_mem({tb_cb(words[1]), words[1]});
        @(negedge clk);
        mem_le = 1'b0;
        mem_d_in = words[2]; mem_cb_in = tb_cb(words[2]) ^ 8'h3; #5;
        check("R6 mem hold data", sys_d_out, words[1]);
        check("R6 mem hold flags", {err_any, err_multi}, 0);
        @(negedge clk);
        mem_le = 1'b1; mem_cb_in = tb_cb(words[2]); #5;
        check("R6 mem reopen", sys_d_out, words[2]);

        // R6 pipeline stage hold.
        @(negedge clk);
        pipe_le = 1'b0;
        mem_d_in = words[1]; mem_cb_in = tb_cb(words[1]) ^ 8'h3; #5;
        check("R6 pipe hold data", sys_d_out, words[2]);
        check("R6 pipe hold flags", {err_any, err_multi}, 0);
        @(negedge clk);
        pipe_le = 1'b1; #5;
        check("R6 pipe reopen flags", {err_any, err_multi}, 2'b11);

        // R6 system stage hold.
        @(negedge clk);
        wr_be = '1; sys_d_in = words[2]; sys_par_in = tb_par(words[2]); #5;
        check("R6 sys open", mem_d_out, words[2]);
        @(negedge clk);
        sys_le = 1'b0; sys_d_in = words[1]; sys_par_in = ~tb_par(words[1]); #5;
        check("R6 sys hold data", mem_d_out, words[2]);
        check("R6 sys hold parity", par_err, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule